// File: doc/BRIEF.md
# Lockable Way Replacement Selector

This block picks the way that a cache fill will overwrite in one level of a 4-way set-associative cache. The cache controller presents the set index together with the valid and lock bits it has just read from the tag array for every way of that set. The block answers one clock later with the way number to overwrite and the lock bit to store alongside the new tag. One instance serves one cache level. The tag storage and the fill datapath stay outside the block.

When no lock is requested, the choice follows a simple order. An empty, unlocked way is taken first. Otherwise a round-robin pointer kept per set index is used, and that search passes over any way whose line is locked. When software has enabled locking and the fill comes from the qualifying operation (a load for a data cache, an instruction-fill operation for an instruction cache), the new line goes into one of the two lockable ways. A one-bit select input picks that way, and the line is marked locked. Locking works one line at a time. If every way of a set is locked, the block flags the fill as uncacheable and nothing is replaced.

Top module: `lockable_victim_sel`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_lock_wr` and `rsp_nocache` are 0, `rsp_way` is 0, and every set index behaves as if its round-robin pointer were 0.
- R2: `rsp_valid` is 1 in exactly the cycles that follow a cycle with `req_valid` = 1, so back-to-back requests are answered back to back.
- R3: When `lock_en` = 1 and `fill_qual` = 1, the response is way 0 (lockable way A) for `lock_sel` = 0 and way 1 (lockable way B) for `lock_sel` = 1, with `rsp_lock_wr` = 1 and `rsp_nocache` = 0. This holds whatever the valid and lock bits are, and the set's pointer is left unchanged.
- R4: When `lock_en` or `fill_qual` is 0, `rsp_lock_wr` = 0 and the victim is chosen by the rules of R5 to R8.
- R5: Without a lock fill, if any way has valid bit 0 and lock bit 0, the lowest-numbered such way is chosen and the set's pointer is left unchanged. Bit k of `way_valid` and `way_lock` belongs to way k.
- R6: Without a lock fill and with no free way, the first way with lock bit 0 is chosen. The search starts at the set's pointer and moves upward with wraparound from way 3 to way 0. The pointer is then set to that way plus one, modulo 4.
- R7: A way with lock bit 1 is never chosen outside a lock fill. The round-robin search passes over it.
- R8: Without a lock fill, if all four lock bits are 1, `rsp_nocache` = 1, `rsp_way` = 0 and `rsp_lock_wr` = 0, and the set's pointer is left unchanged.
- R9: Each set index has its own pointer. A replacement at one index does not move the pointer of any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A fill needs a victim this cycle |
| req_index | input | 6 | Set index of the fill |
| way_valid | input | 4 | Valid bit of each way at that index |
| way_lock | input | 4 | Lock bit of each way at that index |
| lock_en | input | 1 | Locking enabled for this cache level |
| lock_sel | input | 1 | Lockable way to use: 0 = way A, 1 = way B |
| fill_qual | input | 1 | Fill comes from the operation that may lock |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_way | output | 2 | Way to overwrite |
| rsp_lock_wr | output | 1 | Lock bit to store with the new line |
| rsp_nocache | output | 1 | All ways locked: fill is uncacheable |

## Verification
On every cycle, the assertions check four things: the one-cycle response timing, the placement of a lock fill into the selected lockable way, that no locked way is ever returned outside a lock fill, and the uncacheable flag when all four ways are locked. Inside the picker, an assertion also checks that the chosen way was actually available. How the per-index pointer evolves can only be shown by the bench's scenarios. This covers the cyclic order, the pointer staying unchanged after free-way, locked and uncacheable fills, independence between indices, and read-after-write on back-to-back requests to one index.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

  // How the victim of a request was decided.
  typedef enum logic [1:0] {
    SEL_LOCK   = 2'd0,
    SEL_FREE   = 2'd1,
    SEL_CYCLIC = 2'd2,
    SEL_NONE   = 2'd3
  } sel_kind_e;

endpackage

// File: rtl/lvs_ptr_store.sv
// Per-index round-robin pointer storage. The pointer array has no reset,
// so it can map to distributed RAM; a per-index "touched" flag (with reset)
// makes an untouched index read as pointer 0.
module lvs_ptr_store #(
  parameter int SETS = 64,
  parameter int PW   = 2,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_ptr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_ptr
);

  logic [PW-1:0] mem [SETS];
  logic [SETS-1:0] touched;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= '0;
    end else if (wr_en) begin
      touched[wr_idx] <= 1'b1;
    end
  end

  assign rd_ptr = touched[rd_idx] ? mem[rd_idx] : '0;

endmodule

// File: rtl/lvs_first_avail.sv
// Lowest-numbered set bit finder.
module lvs_first_avail #(
  parameter int N  = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] avail,
  output logic         found,
  output logic [W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (avail[k]) begin
        found = 1'b1;
        idx   = W'(k);
      end
    end
  end

endmodule

// File: rtl/lvs_cyclic_pick.sv
// First available way at or after a start position, with wraparound.
// N must be a power of two.
module lvs_cyclic_pick #(
  parameter int N  = 4,
  localparam int W = $clog2(N)
) (
  input  logic [W-1:0] start,
  input  logic [N-1:0] avail,
  output logic         found,
  output logic [W-1:0] idx
);

  logic [N-1:0] rot;
  logic [W-1:0] off;

  // rot[k] is the availability of way (start + k) mod N
  for (genvar k = 0; k < N; k++) begin : g_rot
    logic [W-1:0] src;
    assign src    = start + W'(k);
    assign rot[k] = avail[src];
  end

  lvs_first_avail #(.N(N)) u_first (
    .avail (rot),
    .found (found),
    .idx   (off)
  );

  assign idx = start + off;

  // R6/R7: a returned way must really be available
  always_comb begin
    if (found) begin
      a_pick_avail_r7: assert (avail[idx])
        else $error("cyclic pick returned an unavailable way");
    end
  end

endmodule

// File: rtl/lockable_victim_sel.sv
module lockable_victim_sel #(
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LOCK_WAY_A = 0,
  parameter int LOCK_WAY_B = 1,
  localparam int WW        = $clog2(WAYS),
  localparam int IW        = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [IW-1:0]   req_index,
  input  logic [WAYS-1:0] way_valid,
  input  logic [WAYS-1:0] way_lock,
  input  logic            lock_en,
  input  logic            lock_sel,
  input  logic            fill_qual,
  output logic            rsp_valid,
  output logic [WW-1:0]   rsp_way,
  output logic            rsp_lock_wr,
  output logic            rsp_nocache
);

  import lvs_pkg::*;

  localparam logic [WW-1:0] WAY_A = WW'(LOCK_WAY_A);
  localparam logic [WW-1:0] WAY_B = WW'(LOCK_WAY_B);

  logic [WAYS-1:0] unlocked, free_ways;
  logic            lock_act;
  logic            free_found, cyc_found;
  logic [WW-1:0]   free_idx, cyc_idx, cur_ptr;
  sel_kind_e       kind;
  logic [WW-1:0]   nxt_way;

  assign unlocked  = ~way_lock;
  assign free_ways = ~way_valid & unlocked;
  assign lock_act  = lock_en & fill_qual;

  lvs_ptr_store #(.SETS(SETS), .PW(WW)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (req_index),
    .rd_ptr (cur_ptr),
    .wr_en  (req_valid && (kind == SEL_CYCLIC)),
    .wr_idx (req_index),
    .wr_ptr (cyc_idx + WW'(1))
  );

  lvs_first_avail #(.N(WAYS)) u_free (
    .avail (free_ways),
    .found (free_found),
    .idx   (free_idx)
  );

  lvs_cyclic_pick #(.N(WAYS)) u_cyc (
    .start (cur_ptr),
    .avail (unlocked),
    .found (cyc_found),
    .idx   (cyc_idx)
  );

  always_comb begin
    if (lock_act) begin
      kind    = SEL_LOCK;
      nxt_way = lock_sel ? WAY_B : WAY_A;
    end else if (free_found) begin
      kind    = SEL_FREE;
      nxt_way = free_idx;
    end else if (cyc_found) begin
      kind    = SEL_CYCLIC;
      nxt_way = cyc_idx;
    end else begin
      kind    = SEL_NONE;
      nxt_way = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_way     <= '0;
      rsp_lock_wr <= 1'b0;
      rsp_nocache <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_way     <= nxt_way;
        rsp_lock_wr <= (kind == SEL_LOCK);
        rsp_nocache <= (kind == SEL_NONE);
      end
    end
  end

  // ---------------- assertions ----------------
  logic [WAYS-1:0] chk_lock_q;
  always_ff @(posedge clk) begin
    chk_lock_q <= way_lock;
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_lock_fill_way_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lock_en && fill_qual) |=>
      (rsp_lock_wr && !rsp_nocache && rsp_way == ($past(lock_sel) ? WAY_B : WAY_A)));

  p_no_lock_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(lock_en && fill_qual)) |=> !rsp_lock_wr);

  p_skip_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(lock_en && fill_qual)) |=> (rsp_nocache || !chk_lock_q[rsp_way]));

  p_all_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(lock_en && fill_qual) && (&way_lock)) |=>
      (rsp_nocache && !rsp_lock_wr && rsp_way == '0));

endmodule

// File: tb/sim_lockable_victim_sel.sv
`timescale 1ns/1ps
module sim_lockable_victim_sel;

  localparam int WAYS = 4;
  localparam int SETS = 64;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [5:0] req_index;
  logic [3:0] way_valid, way_lock;
  logic       lock_en, lock_sel, fill_qual;
  logic       rsp_valid;
  logic [1:0] rsp_way;
  logic       rsp_lock_wr, rsp_nocache;

  int n_chk = 0;
  int n_bad = 0;
  int ptr_m [SETS];

  always #10 clk = ~clk;

  lockable_victim_sel u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .way_valid(way_valid), .way_lock(way_lock), .lock_en(lock_en),
    .lock_sel(lock_sel), .fill_qual(fill_qual), .rsp_valid(rsp_valid),
    .rsp_way(rsp_way), .rsp_lock_wr(rsp_lock_wr), .rsp_nocache(rsp_nocache)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request (caller is at a negedge), check the response at the
  // following negedge, and leave req_valid low.
  task automatic issue(input string req, input int idx, input logic [3:0] v,
                       input logic [3:0] l, input logic le, input logic ls,
                       input logic q);
    int ew, elw, enc;
    ew = 0; elw = 0; enc = 0;
    if (le && q) begin
      ew = ls ? 1 : 0; elw = 1;
    end else begin
      int found = 0;
      for (int k = 0; k < WAYS; k++)
        if (!found && !v[k] && !l[k]) begin ew = k; found = 1; end
      if (!found)
        for (int k = 0; k < WAYS; k++) begin
          int w = (ptr_m[idx] + k) % WAYS;
          if (!found && !l[w]) begin ew = w; found = 1; end
        end
      if (found && (v & ~l) == (~l & 4'hF) && (~v & ~l & 4'hF) == 0)
        ptr_m[idx] = (ew + 1) % WAYS;
      if (!found) begin enc = 1; ew = 0; end
    end
    req_valid = 1; req_index = 6'(idx); way_valid = v; way_lock = l;
    lock_en = le; lock_sel = ls; fill_qual = q;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, int'(rsp_valid), 1);
    chk({req, " way"}, int'(rsp_way), ew);
    chk({req, " lock_wr"}, int'(rsp_lock_wr), elw);
    chk({req, " nocache"}, int'(rsp_nocache), enc);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(rsp_valid), 0);
    chk("R1 way", int'(rsp_way), 0);
    chk("R1 lock_wr", int'(rsp_lock_wr), 0);
    chk("R1 nocache", int'(rsp_nocache), 0);
    issue("R1 ptr0", 40, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_cyclic;
    for (int i = 0; i < 5; i++) issue("R6 cyclic", 5, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_index;
    issue("R9 fresh idx", 9, 4'hF, 4'h0, 0, 0, 0);
    issue("R9 old idx", 5, 4'hF, 4'h0, 0, 0, 0);
    issue("R9 idx9 again", 9, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_skip;
    for (int i = 0; i < 3; i++) issue("R7 skip 0011", 12, 4'hF, 4'b0011, 0, 0, 0);
    for (int i = 0; i < 3; i++) issue("R7 skip 0010", 12, 4'hF, 4'b0010, 0, 0, 0);
  endtask

  task automatic t_free;
    issue("R5 free way2", 20, 4'b1011, 4'h0, 0, 0, 0);
    issue("R5 free way3", 20, 4'b0110, 4'b0001, 0, 0, 0);
    issue("R5 locked invalid", 20, 4'b1110, 4'b0001, 0, 0, 0);
    issue("R5 ptr after", 20, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_lock;
    issue("R3 lock A", 30, 4'b0001, 4'h0, 1, 0, 1);
    issue("R3 lock B", 30, 4'hF, 4'b0011, 1, 1, 1);
    issue("R3 ptr kept", 30, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_noqual;
    issue("R4 en no qual", 31, 4'hF, 4'h0, 1, 1, 0);
    issue("R4 qual no en", 31, 4'hF, 4'h0, 0, 1, 1);
  endtask

  task automatic t_all_locked;
    issue("R8 all locked", 33, 4'hF, 4'hF, 0, 0, 0);
    issue("R8 ptr kept", 33, 4'hF, 4'h0, 0, 0, 0);
  endtask

  task automatic t_idle;
    issue("R2 single", 50, 4'hF, 4'h0, 0, 0, 0);
    @(negedge clk);
    chk("R2 idle drop", int'(rsp_valid), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS; i++) ptr_m[i] = 0;
    rst = 1; req_valid = 0; req_index = '0; way_valid = '0; way_lock = '0;
    lock_en = 0; lock_sel = 0; fill_qual = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_cyclic;
    t_index;
    t_skip;
    t_free;
    t_lock;
    t_noqual;
    t_all_locked;
    t_idle;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule